// File: doc/BRIEF.md
# Descriptor-chained DMA channel

This block is one DMA channel that takes its work from a linked list of descriptors in memory. Software writes the address of the first descriptor and then sets Run. The channel reads a four-word descriptor from a 16-byte-aligned address and loads its pointer, source, target and command registers from it. It then copies the programmed byte count from source to target one 32-bit word at a time. When the count runs out, the channel either fetches the next descriptor in the chain or halts.

A direct mode skips the descriptor fetch. In that mode the channel moves the data that the source, target and command registers hold and then halts. Three sticky event flags record the events that matter to software: a descriptor was loaded, the byte count ran out, and the memory port returned an error. Software clears each flag by writing 1 to it. A single level interrupt combines these flags with their enables. One word-wide memory master with a request/grant handshake carries both the descriptor fetches and the data moves.

Top module: `dchain_dma`

## Requirements
- R1: After reset, the control/status word (register index 0) reads 0x0000_0008, meaning only the stopped bit 3 is set. `irq` and `mem_req` are both 0.
- R2: In descriptor mode, the channel reads four consecutive words starting at the pointer register (index 1) with bits 3:0 forced to zero. It loads them, in order, into the pointer, source (index 2), target (index 3) and command (index 4) registers. It then sets the start flag, control bit 1.
- R3: A data move performs one word read at the source address, then one word write of that data at the target address. This pair repeats ceil(L/4) times, where L is command bits 12:0. The first access uses the first source and target addresses.
- R4: Command bit 31 set makes the source address advance by 4 after each word, and command bit 30 does the same for the target address. When a bit is clear, its address stays fixed. The registers keep their final values after the move.
- R5: After a move, if bit 0 of the pointer register is 1 the channel halts. If it is 0, the channel fetches the next descriptor at pointer bits 31:4.
- R6: With control bit 30 set when Run (bit 31) is written, the channel fetches no descriptor. It moves data using the directly written registers, leaves the start flag clear, and halts afterwards.
- R7: Command bits 12:0 count down to 0 during the move. The end flag, control bit 2, is set once the count reaches zero. A length of 0 moves no data but still sets the end flag.
- R8: Writing 1 to control bit 2, 1 or 0 clears the end, start or bus-error flag respectively. Writing 0 to a flag bit leaves that flag unchanged.
- R9: `irq` is high exactly when at least one of the following holds:
  - the start flag is set and command bit 22 is set;
  - the end flag is set and command bit 21 is set;
  - the bus-error flag is set;
  - control bit 29 is set and the channel is stopped.
- R10: A memory response with `mem_err` sets the bus-error flag and clears Run. The channel is then stopped and issues no further requests, and a data write is never performed after an error.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R12: While the channel is not stopped, writes to registers 1 to 4 are ignored. Writes to the Run, direct-mode and stop-enable bits are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control/status, 1 pointer, 2 source, 3 target, 4 command) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| mem_err | input | 1 | Error response, valid with `mem_gnt` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with the package defaults: a 32-bit word, a 13-bit length field and 4-byte steps. Its memory model answers after a pseudo-random wait of zero to two cycles and returns an error for any address with bit 12 set. With these settings, short lengths reach rounding up to whole words, the zero-length case, fixed and incrementing addresses, a two-descriptor chain and direct mode. A 64-byte move is long enough that register writes can be issued in the middle of a transfer.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    localparam int DW         = 32;
    localparam int LEN_W      = 13;
    localparam int STEP       = DW / 8;
    localparam int DESC_ALIGN = 4;
    localparam int REG_AW     = 3;

    // control/status bit positions
    localparam int CS_RUN     = 31;
    localparam int CS_DIRECT  = 30;
    localparam int CS_STOPIE  = 29;
    localparam int CS_END     = 2;
    localparam int CS_START   = 1;
    localparam int CS_BUSERR  = 0;

    // command word bit positions
    localparam int CMD_SRCINC  = 31;
    localparam int CMD_TGTINC  = 30;
    localparam int CMD_STARTIE = 22;
    localparam int CMD_ENDIE   = 21;

    localparam int PTR_HALT = 0;

    typedef enum logic [REG_AW-1:0] {
        RI_CTRL = 3'd0,
        RI_PTR  = 3'd1,
        RI_SRC  = 3'd2,
        RI_TGT  = 3'd3,
        RI_CMD  = 3'd4
    } reg_idx_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_CLOSE
    } eng_state_e;

    typedef struct packed {
        logic loaded;
        logic done;
        logic fault;
        logic halt;
    } eng_evt_t;

    function automatic logic [LEN_W-1:0] len_after_word(input logic [LEN_W-1:0] l);
        return (l <= LEN_W'(STEP)) ? '0 : l - LEN_W'(STEP);
    endfunction

    function automatic logic [DW-1:0] desc_base(input logic [DW-1:0] p);
        return {p[DW-1:DESC_ALIGN], {DESC_ALIGN{1'b0}}};
    endfunction

endpackage

// File: rtl/dchain_engine.sv
module dchain_engine
    import dchain_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          direct,
    input  logic [3:0]    sw_we,
    input  logic [DW-1:0] sw_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          busy,
    output eng_evt_t      evt,
    output logic [DW-1:0] ptr_q,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] tgt_q,
    output logic [DW-1:0] cmd_q
);

    eng_state_e    state;
    logic [1:0]    fidx;
    logic [DW-1:0] fbase;
    logic [DW-1:0] buf_q;
    logic          xfer;
    logic          fault;
    logic          chain_end;

    assign xfer      = mem_req & mem_gnt;
    assign fault     = xfer & mem_err;
    assign chain_end = direct | ptr_q[PTR_HALT];
    assign busy      = (state != ST_IDLE);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = tgt_q;
        mem_wdata = buf_q;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fbase | {{(DW-4){1'b0}}, fidx, 2'b00};
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        evt.loaded = (state == ST_FETCH) & xfer & ~mem_err & (fidx == 2'd3);
        evt.done   = (state == ST_CLOSE);
        evt.fault  = fault;
        evt.halt   = fault | ((state == ST_CLOSE) & chain_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fidx  <= '0;
            fbase <= '0;
            buf_q <= '0;
            ptr_q <= '0;
            src_q <= '0;
            tgt_q <= '0;
            cmd_q <= '0;
        end else begin
            if (sw_we[0]) ptr_q <= sw_wdata;
            if (sw_we[1]) src_q <= sw_wdata;
            if (sw_we[2]) tgt_q <= sw_wdata;
            if (sw_we[3]) cmd_q <= sw_wdata;
            case (state)
                ST_IDLE: begin
                    if (run) begin
                        if (direct) begin
                            state <= (cmd_q[LEN_W-1:0] == '0) ? ST_CLOSE : ST_READ;
                        end else begin
                            fbase <= desc_base(ptr_q);
                            fidx  <= '0;
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (xfer) begin
                        if (mem_err) begin
                            state <= ST_IDLE;
                        end else begin
                            fidx <= fidx + 2'd1;
                            case (fidx)
                                2'd0: ptr_q <= mem_rdata;
                                2'd1: src_q <= mem_rdata;
                                2'd2: tgt_q <= mem_rdata;
                                default: begin
                                    cmd_q <= mem_rdata;
                                    state <= (mem_rdata[LEN_W-1:0] == '0) ? ST_CLOSE : ST_READ;
                                end
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    if (xfer) begin
                        if (mem_err) begin
                            state <= ST_IDLE;
                        end else begin
                            buf_q <= mem_rdata;
                            state <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (xfer) begin
                        if (mem_err) begin
                            state <= ST_IDLE;
                        end else begin
                            if (cmd_q[CMD_SRCINC]) src_q <= src_q + DW'(STEP);
                            if (cmd_q[CMD_TGTINC]) tgt_q <= tgt_q + DW'(STEP);
                            cmd_q[LEN_W-1:0] <= len_after_word(cmd_q[LEN_W-1:0]);
                            state <= (cmd_q[LEN_W-1:0] <= LEN_W'(STEP)) ? ST_CLOSE : ST_READ;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (chain_end) begin
                        state <= ST_IDLE;
                    end else begin
                        fbase <= desc_base(ptr_q);
                        fidx  <= '0;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dchain_csr.sv
module dchain_csr
    import dchain_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [2:0]    mode_bits,
    input  logic [2:0]    clr_bits,
    input  logic          busy,
    input  eng_evt_t      evt,
    input  logic          start_ie,
    input  logic          end_ie,
    output logic          run,
    output logic          direct,
    output logic          stopped,
    output logic          irq,
    output logic [DW-1:0] status
);

    logic stop_ie;
    logic f_end;
    logic f_start;
    logic f_err;

    assign stopped = ~busy & ~run;
    assign irq     = (f_start & start_ie) | (f_end & end_ie) | f_err | (stop_ie & stopped);
    assign status  = {run, direct, stop_ie, {(DW-7){1'b0}}, stopped, f_end, f_start, f_err};

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            direct  <= 1'b0;
            stop_ie <= 1'b0;
            f_end   <= 1'b0;
            f_start <= 1'b0;
            f_err   <= 1'b0;
        end else begin
            if (wr && stopped) begin
                run     <= mode_bits[2];
                direct  <= mode_bits[1];
                stop_ie <= mode_bits[0];
            end
            if (evt.halt) run <= 1'b0;
            f_end   <= evt.done   | (f_end   & ~(wr & clr_bits[2]));
            f_start <= evt.loaded | (f_start & ~(wr & clr_bits[1]));
            f_err   <= evt.fault  | (f_err   & ~(wr & clr_bits[0]));
        end
    end

endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_gnt,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_err,
    output logic              irq
);

    logic          run_w;
    logic          direct_w;
    logic          stopped_w;
    logic          busy_w;
    logic          ctrl_wr;
    logic [3:0]    sw_we;
    logic [DW-1:0] status_w;
    logic [DW-1:0] ptr_w;
    logic [DW-1:0] src_w;
    logic [DW-1:0] tgt_w;
    logic [DW-1:0] cmd_w;
    eng_evt_t      evt_w;

    assign ctrl_wr = reg_wr && (reg_addr == RI_CTRL);

    for (genvar g = 0; g < 4; g++) begin : g_swwe
        assign sw_we[g] = reg_wr && stopped_w && (reg_addr == REG_AW'(int'(RI_PTR) + g));
    end

    dchain_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctrl_wr),
        .mode_bits (reg_wdata[CS_RUN:CS_STOPIE]),
        .clr_bits  (reg_wdata[CS_END:CS_BUSERR]),
        .busy      (busy_w),
        .evt       (evt_w),
        .start_ie  (cmd_w[CMD_STARTIE]),
        .end_ie    (cmd_w[CMD_ENDIE]),
        .run       (run_w),
        .direct    (direct_w),
        .stopped   (stopped_w),
        .irq       (irq),
        .status    (status_w)
    );

    dchain_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .run       (run_w),
        .direct    (direct_w),
        .sw_we     (sw_we),
        .sw_wdata  (reg_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .busy      (busy_w),
        .evt       (evt_w),
        .ptr_q     (ptr_w),
        .src_q     (src_w),
        .tgt_q     (tgt_w),
        .cmd_q     (cmd_w)
    );

    always_comb begin
        case (reg_addr)
            RI_CTRL: reg_rdata = status_w;
            RI_PTR:  reg_rdata = ptr_w;
            RI_SRC:  reg_rdata = src_w;
            RI_TGT:  reg_rdata = tgt_w;
            RI_CMD:  reg_rdata = cmd_w;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dchain_dma_chk.sv
module dchain_dma_chk
    import dchain_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_gnt,
    input logic          mem_err,
    input logic          run,
    input logic          stopped,
    input logic          err_flag
);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !mem_req);

    assert_err_halts_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && mem_err) |=> (stopped && !run && err_flag));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(mem_req && mem_gnt && mem_err));

endmodule

bind dchain_dma dchain_dma_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_err   (mem_err),
    .run       (run_w),
    .stopped   (stopped_w),
    .err_flag  (status_w[0])
);

// File: tb/dchain_dma_tb_top.sv
`timescale 1ns/1ps
module dchain_dma_tb_top;
    import dchain_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [31:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_gnt = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          mem_err = 1'b0;
    logic          irq;

    always #10 clk = ~clk;

    dchain_dma dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
    } wr_item_t;

    logic [31:0] mem [0:1023];
    wr_item_t    expq [$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          n_rd  = 0;
    int          n_wr  = 0;
    int          wait_cnt = 0;
    logic [7:0]  lfsr = 8'h5B;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] hold_data = '0;
    logic        finished = 1'b0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0000_9E37) ^ 32'h1234_5678;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    // memory model and write monitor (scoreboard pop side)
    always @(negedge clk) begin
        if (rst) begin
            mem_gnt   = 1'b0;
            mem_err   = 1'b0;
            hold_pend = 1'b0;
        end else begin
            if (hold_pend) begin
                check("R11 address held while waiting", mem_addr, hold_addr);
                check("R11 write data held while waiting", mem_wdata, hold_data);
            end
            if (mem_req) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                    mem_gnt   = 1'b0;
                    mem_err   = 1'b0;
                    hold_pend = 1'b1;
                    hold_addr = mem_addr;
                    hold_data = mem_wdata;
                end else begin
                    hold_pend = 1'b0;
                    mem_gnt   = 1'b1;
                    mem_err   = mem_addr[12];
                    mem_rdata = mem_addr[12] ? 32'hDEAD_BEEF : mem[mem_addr[11:2]];
                    if (mem_we) begin
                        n_wr++;
                        if (!mem_addr[12]) mem[mem_addr[11:2]] = mem_wdata;
                        if (expq.size() == 0) begin
                            check("R3 unexpected write address", mem_addr, 32'hFFFF_FFFF);
                        end else begin
                            wr_item_t it;
                            it = expq.pop_front();
                            check("R3 R4 write address", mem_addr, it.a);
                            check("R3 write data", mem_wdata, it.d);
                        end
                    end else begin
                        n_rd++;
                    end
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    wait_cnt = int'(lfsr) % 3;
                end
            end else begin
                mem_gnt   = 1'b0;
                mem_err   = 1'b0;
                hold_pend = 1'b0;
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            reg_read(3'd0, v);
            if (v[3]) return;
        end
        check("R3 channel never stopped", v, v | 32'h8);
    endtask

    // scoreboard push side
    task automatic push_move(input logic [31:0] src, input logic [31:0] tgt,
                             input int len, input bit si, input bit ti);
        int n;
        n = (len + 3) / 4;
        for (int k = 0; k < n; k++) begin
            wr_item_t it;
            it.a = tgt + (ti ? 32'(4 * k) : 32'd0);
            it.d = pat(src + (si ? 32'(4 * k) : 32'd0));
            expq.push_back(it);
        end
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                            input logic [31:0] src, input logic [31:0] tgt,
                            input logic [31:0] cmd);
        mem[base[11:2]]     = nxt;
        mem[base[11:2] + 1] = src;
        mem[base[11:2] + 2] = tgt;
        mem[base[11:2] + 3] = cmd;
    endtask

    initial begin
        #(20 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int rd0;
        int wr0;
        for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i * 4));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(3'd0, v);
        check("R1 control word after reset", v, 32'h0000_0008);
        check("R1 irq after reset", irq, 0);
        check("R1 mem_req after reset", mem_req, 0);

        // single descriptor, rounding 10 bytes to 3 words
        put_desc(32'h100, 32'h0000_0001, 32'h200, 32'h400, 32'hC060_C00A);
        reg_write(3'd1, 32'h0000_0107);
        push_move(32'h200, 32'h400, 10, 1, 1);
        reg_write(3'd0, 32'h8000_0000);
        wait_stop();
        check("R3 all words written", expq.size(), 0);
        reg_read(3'd0, v);
        check("R2 R7 start and end flags set", v, 32'h0000_000E);
        reg_read(3'd1, v);
        check("R2 pointer loaded from descriptor", v, 32'h0000_0001);
        reg_read(3'd2, v);
        check("R4 source advanced", v, 32'h0000_020C);
        reg_read(3'd3, v);
        check("R4 target advanced", v, 32'h0000_040C);
        reg_read(3'd4, v);
        check("R7 length counted to zero", v, 32'hC060_C000);
        check("R9 irq from start and end", irq, 1);

        // R8 write-one-to-clear
        reg_write(3'd0, 32'h0000_0004);
        reg_read(3'd0, v);
        check("R8 end cleared only", v, 32'h0000_000A);
        check("R9 irq held by start flag", irq, 1);
        reg_write(3'd0, 32'h0000_0000);
        reg_read(3'd0, v);
        check("R8 writing zero keeps flag", v, 32'h0000_000A);
        reg_write(3'd0, 32'h0000_0002);
        reg_read(3'd0, v);
        check("R8 start cleared", v, 32'h0000_0008);
        check("R9 irq low with no flags", irq, 0);

        // R5 two-descriptor chain, fixed target then fixed source
        put_desc(32'h120, 32'h0000_0140, 32'h300, 32'h480, 32'h8000_0008);
        put_desc(32'h140, 32'h0000_0001, 32'h310, 32'h4A0, 32'h4000_0004);
        push_move(32'h300, 32'h480, 8, 1, 0);
        push_move(32'h310, 32'h4A0, 4, 0, 1);
        reg_write(3'd1, 32'h0000_0120);
        reg_write(3'd0, 32'h8000_0000);
        wait_stop();
        check("R5 both descriptors moved", expq.size(), 0);
        reg_read(3'd2, v);
        check("R4 fixed source stays", v, 32'h0000_0310);
        reg_read(3'd3, v);
        check("R4 target advanced in second", v, 32'h0000_04A4);
        check("R4 fixed target holds last word", mem[32'h480 >> 2], pat(32'h304));
        reg_read(3'd1, v);
        check("R5 halt flag from second pointer", v, 32'h0000_0001);
        check("R9 irq low without enables", irq, 0);
        reg_write(3'd0, 32'h0000_0007);

        // R7 zero length
        put_desc(32'h160, 32'h0000_0001, 32'h200, 32'h500, 32'hC060_0000);
        rd0 = n_rd;
        wr0 = n_wr;
        reg_write(3'd1, 32'h0000_0160);
        reg_write(3'd0, 32'h8000_0000);
        wait_stop();
        check("R7 zero length writes nothing", n_wr - wr0, 0);
        check("R2 zero length reads only descriptor", n_rd - rd0, 4);
        reg_read(3'd0, v);
        check("R7 end flag on zero length", v, 32'h0000_000E);
        reg_write(3'd0, 32'h0000_0007);

        // R6 direct mode
        reg_write(3'd2, 32'h0000_0320);
        reg_write(3'd3, 32'h0000_04C0);
        reg_write(3'd4, 32'hC000_0005);
        push_move(32'h320, 32'h4C0, 5, 1, 1);
        rd0 = n_rd;
        reg_write(3'd0, 32'hC000_0000);
        wait_stop();
        check("R6 direct move written", expq.size(), 0);
        check("R6 no descriptor reads", n_rd - rd0, 2);
        reg_read(3'd0, v);
        check("R6 no start flag in direct mode", v, 32'h4000_000C);
        reg_write(3'd0, 32'h0000_0007);

        // R10 bus error, with stop interrupt enable
        reg_write(3'd2, 32'h0000_1000);
        reg_write(3'd3, 32'h0000_0600);
        reg_write(3'd4, 32'h0000_0004);
        wr0 = n_wr;
        reg_write(3'd0, 32'hE000_0000);
        wait_stop();
        reg_read(3'd0, v);
        check("R10 error flag, run clear, stopped", v, 32'h6000_0009);
        check("R10 no write after error", n_wr - wr0, 0);
        check("R9 irq on error", irq, 1);
        reg_write(3'd0, 32'h6000_0001);
        reg_read(3'd0, v);
        check("R8 error flag cleared", v, 32'h6000_0008);
        check("R9 irq from stop enable", irq, 1);
        reg_write(3'd0, 32'h0000_0000);
        check("R9 irq low after stop enable cleared", irq, 0);

        // R12 writes ignored while running
        reg_write(3'd2, 32'h0000_0240);
        reg_write(3'd3, 32'h0000_0700);
        reg_write(3'd4, 32'hC000_0040);
        push_move(32'h240, 32'h700, 64, 1, 1);
        reg_write(3'd0, 32'hC000_0000);
        reg_write(3'd2, 32'h0000_1000);
        reg_write(3'd4, 32'h0000_0001);
        reg_write(3'd0, 32'h0000_0000);
        reg_read(3'd0, v);
        check("R12 run not cleared by write while busy", v[31], 1);
        wait_stop();
        check("R12 full move despite writes", expq.size(), 0);
        reg_read(3'd2, v);
        check("R12 source not overwritten", v, 32'h0000_0280);

        summary();
        $finish;
    end

endmodule